// File: doc/BRIEF.md
# PWM Complementary Pair Output Conditioner

This block sits between a duty-cycle generator and the two pins of a complementary PWM pair, the high-side and low-side drivers. It decides what each pin shows on every clock. A current-limit condition can force a fixed two-bit pattern onto the pins. A software override can replace the generator's signals with its own two-bit pattern. Otherwise the raw generator signals pass through. The last step can exchange the two signals between the pins, and the pins are registered.

Software override data is written into a shadow register. It moves into the active override register either on every clock or only on a PWM period-boundary strobe, depending on the synchronization mode. The fault mode, the swap setting and the synchronization mode are configuration. The block samples them only while the module is disabled, so a running pair cannot be reconfigured partway through a period. While the module is disabled, both pins are held low.

Top module: `pwm_pair_override`

## Requirements
- R1: While reset is asserted, and on the first clock after reset is released, both pins are low.
- R2: When `mod_en` is low at a clock edge, both pins are low after that edge.
- R3: With the module enabled, no current limit applying and the active override disabled, `pin_hi` and `pin_lo` show the values that `pwm_hi_in` and `pwm_lo_in` had at the previous clock edge (one clock of latency), subject to R7.
- R4: In normal fault mode (`fault_indep`=0 latched), while `ilim_act` is high, `ilim_dat[1]` drives the high side and `ilim_dat[0]` drives the low side. This takes priority over the override and the raw signals, subject to R7.
- R5: In independent fault mode (`fault_indep`=1 latched), `ilim_dat` and `ilim_act` have no effect, and the pins follow the override or raw path.
- R6: When the active override enable is 1 and R4 does not apply, the active override bit 1 drives the high side and bit 0 drives the low side, in place of the raw signals.
- R7: When the latched swap setting is 1, the high-side result appears on `pin_lo` and the low-side result appears on `pin_hi`. When it is 0, each result goes to its own pin.
- R8: Override values (`ovr_en`, `ovr_dat`) on the ports at clock edge k are written into the shadow register. In immediate mode (latched `ovr_sync`=0), the shadow is copied to the active register at edge k+1, so the effect on the pins is visible after edge k+2.
- R9: In synchronized mode (latched `ovr_sync`=1), the active override register changes only at an edge where `period_strobe` is high. At that edge it loads the current shadow contents.
- R10: `fault_indep`, `swap_en` and `ovr_sync` are latched at every edge where `mod_en` is low and are held unchanged while `mod_en` is high. Changes made to them while the module is enabled are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mod_en | input | 1 | Module enable; configuration is latched while it is low |
| pwm_hi_in | input | 1 | Raw high-side PWM signal |
| pwm_lo_in | input | 1 | Raw low-side PWM signal |
| ilim_act | input | 1 | Current limit is active |
| fault_indep | input | 1 | Fault mode: 0 normal, 1 independent |
| ilim_dat | input | 2 | Current-limit pin data, bit 1 high side, bit 0 low side |
| swap_en | input | 1 | Exchange the high and low results between the pins |
| ovr_en | input | 1 | Software override enable (shadow write data) |
| ovr_dat | input | 2 | Software override pin data, bit 1 high side, bit 0 low side |
| ovr_sync | input | 1 | 1: override updates at the period strobe; 0: on the next clock |
| period_strobe | input | 1 | PWM time-base period boundary, one clock wide |
| pin_hi | output | 1 | High-side pin |
| pin_lo | output | 1 | Low-side pin |

## Verification
The bench looks for mistakes in priority: current limit asserted together with an override, where a design that puts the override first would show the software pattern. It also drives independent fault mode with current-limit data that differs from the override, where a design that still substituted the limit data would expose `ilim_dat`. It changes swap and fault mode while the module is enabled and again while it is disabled, which catches a design that reconfigures a running pair. In synchronized mode it changes override data between strobes, where a design that copies the shadow early would move the pins before the boundary.

// File: rtl/pwm_ovr_pkg.sv
package pwm_ovr_pkg;
   localparam int unsigned PAIR_W = 2;
   localparam int unsigned HI_BIT = PAIR_W - 1;
   localparam int unsigned LO_BIT = 0;

   typedef struct packed {
      logic indep;
      logic swap;
      logic sync;
   } ovr_cfg_t;

   typedef struct packed {
      logic              en;
      logic [PAIR_W-1:0] dat;
   } ovr_word_t;
endpackage

// File: rtl/pwm_ovr_cfg.sv
module pwm_ovr_cfg
   import pwm_ovr_pkg::*;
(
   input  logic     clk,
   input  logic     rst_n,
   input  logic     mod_en,
   input  ovr_cfg_t cfg_in,
   output ovr_cfg_t cfg_q
);
   always_ff @(posedge clk) begin
      if (!rst_n)       cfg_q <= '0;
      else if (!mod_en) cfg_q <= cfg_in;
   end

   // R10
   cfg_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mod_en |=> $stable(cfg_q));
endmodule

// File: rtl/pwm_ovr_shadow.sv
module pwm_ovr_shadow
   import pwm_ovr_pkg::*;
(
   input  logic      clk,
   input  logic      rst_n,
   input  logic      sync_mode,
   input  logic      period_strobe,
   input  ovr_word_t wr_word,
   output ovr_word_t act_word
);
   ovr_word_t shadow_q;
   logic      load;

   assign load = !sync_mode || period_strobe;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         shadow_q <= '0;
         act_word <= '0;
      end else begin
         shadow_q <= wr_word;
         if (load) act_word <= shadow_q;
      end
   end

   // R9
   sync_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (sync_mode && !period_strobe) |=> $stable(act_word));
   // R8
   imm_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !sync_mode |=> (act_word == $past(shadow_q)));
endmodule

// File: rtl/pwm_ovr_mux.sv
module pwm_ovr_mux
   import pwm_ovr_pkg::*;
#(
   parameter bit HAS_SWAP = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              mod_en,
   input  ovr_cfg_t          cfg,
   input  logic [PAIR_W-1:0] raw,
   input  logic              ilim_act,
   input  logic [PAIR_W-1:0] ilim_dat,
   input  ovr_word_t         act_word,
   output logic              pin_hi,
   output logic              pin_lo
);
   logic [PAIR_W-1:0] pri_sel;
   logic [PAIR_W-1:0] pin_nxt;

   always_comb begin
      pri_sel = raw;
      if (act_word.en)             pri_sel = act_word.dat;
      if (ilim_act && !cfg.indep)  pri_sel = ilim_dat;
   end

   generate
      if (HAS_SWAP) begin : g_swap
         assign pin_nxt = cfg.swap ? {pri_sel[LO_BIT], pri_sel[HI_BIT]} : pri_sel;
      end else begin : g_noswap
         assign pin_nxt = pri_sel;
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n || !mod_en) begin
         pin_hi <= 1'b0;
         pin_lo <= 1'b0;
      end else begin
         pin_hi <= pin_nxt[HI_BIT];
         pin_lo <= pin_nxt[LO_BIT];
      end
   end

   // R2
   disabled_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !mod_en |=> (!pin_hi && !pin_lo));
   // R4
   ilim_norm_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mod_en && ilim_act && !cfg.indep) |=>
         ({pin_hi, pin_lo} == ((HAS_SWAP && $past(cfg.swap)) ?
            {$past(ilim_dat[LO_BIT]), $past(ilim_dat[HI_BIT])} : $past(ilim_dat))));
endmodule

// File: rtl/pwm_pair_override.sv
module pwm_pair_override
   import pwm_ovr_pkg::*;
#(
   parameter bit          HAS_SWAP = 1'b1,
   parameter int unsigned DATA_W   = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              mod_en,
   input  logic              pwm_hi_in,
   input  logic              pwm_lo_in,
   input  logic              ilim_act,
   input  logic              fault_indep,
   input  logic [DATA_W-1:0] ilim_dat,
   input  logic              swap_en,
   input  logic              ovr_en,
   input  logic [DATA_W-1:0] ovr_dat,
   input  logic              ovr_sync,
   input  logic              period_strobe,
   output logic              pin_hi,
   output logic              pin_lo
);
   generate
      if (DATA_W != PAIR_W) begin : g_bad_width
         $error("pwm_pair_override: DATA_W must equal the pin pair width");
      end
   endgenerate

   ovr_cfg_t  cfg_in, cfg_q;
   ovr_word_t wr_word, act_word;

   assign cfg_in  = '{indep: fault_indep, swap: swap_en, sync: ovr_sync};
   assign wr_word = '{en: ovr_en, dat: ovr_dat[PAIR_W-1:0]};

   pwm_ovr_cfg u_cfg (
      .clk    (clk),
      .rst_n  (rst_n),
      .mod_en (mod_en),
      .cfg_in (cfg_in),
      .cfg_q  (cfg_q)
   );

   pwm_ovr_shadow u_shadow (
      .clk           (clk),
      .rst_n         (rst_n),
      .sync_mode     (cfg_q.sync),
      .period_strobe (period_strobe),
      .wr_word       (wr_word),
      .act_word      (act_word)
   );

   pwm_ovr_mux #(.HAS_SWAP(HAS_SWAP)) u_mux (
      .clk      (clk),
      .rst_n    (rst_n),
      .mod_en   (mod_en),
      .cfg      (cfg_q),
      .raw      ({pwm_hi_in, pwm_lo_in}),
      .ilim_act (ilim_act),
      .ilim_dat (ilim_dat[PAIR_W-1:0]),
      .act_word (act_word),
      .pin_hi   (pin_hi),
      .pin_lo   (pin_lo)
   );
endmodule

// File: tb/pwm_pair_override_test.sv
`timescale 1ns/1ps
module pwm_pair_override_test;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic mod_en = 0, pwm_hi_in = 0, pwm_lo_in = 0, ilim_act = 0, fault_indep = 0;
   logic [1:0] ilim_dat = 0, ovr_dat = 0;
   logic swap_en = 0, ovr_en = 0, ovr_sync = 0, period_strobe = 0;
   logic pin_hi, pin_lo;

   int checks = 0, errors = 0;
   bit done = 0;
   string phase = "init";
   string path = "R1";

   // reference model state
   bit m_indep, m_swap, m_sync;
   bit sh_en, ac_en;
   bit [1:0] sh_dat, ac_dat;
   bit exp_hi, exp_lo;

   always #2.5 clk = ~clk;

   pwm_pair_override uut (
      .clk(clk), .rst_n(rst_n), .mod_en(mod_en), .pwm_hi_in(pwm_hi_in),
      .pwm_lo_in(pwm_lo_in), .ilim_act(ilim_act), .fault_indep(fault_indep),
      .ilim_dat(ilim_dat), .swap_en(swap_en), .ovr_en(ovr_en), .ovr_dat(ovr_dat),
      .ovr_sync(ovr_sync), .period_strobe(period_strobe),
      .pin_hi(pin_hi), .pin_lo(pin_lo)
   );

   always @(posedge clk) begin
      bit h, l, t;
      if (!rst_n) begin
         m_indep = 0; m_swap = 0; m_sync = 0;
         sh_en = 0; ac_en = 0; sh_dat = 0; ac_dat = 0;
         exp_hi = 0; exp_lo = 0; path = "R1";
      end else begin
         h = pwm_hi_in; l = pwm_lo_in; path = "R3";
         if (ac_en) begin h = ac_dat[1]; l = ac_dat[0]; path = "R6"; end
         if (ilim_act && !m_indep) begin h = ilim_dat[1]; l = ilim_dat[0]; path = "R4"; end
         else if (ilim_act) path = {path, "+R5"};
         if (m_swap) begin t = h; h = l; l = t; path = {path, "+R7"}; end
         if (!mod_en) begin h = 0; l = 0; path = "R2"; end
         exp_hi = h; exp_lo = l;
         if (!m_sync || period_strobe) begin ac_en = sh_en; ac_dat = sh_dat; end
         sh_en = ovr_en; sh_dat = ovr_dat;
         if (!mod_en) begin m_indep = fault_indep; m_swap = swap_en; m_sync = ovr_sync; end
      end
   end

   always @(negedge clk) begin
      if (!done) begin
         checks++;
         if (pin_hi !== exp_hi || pin_lo !== exp_lo) begin
            errors++;
            $display("FAIL %s [%s] pins hi/lo actual %b%b expected %b%b at %0t",
                     path, phase, pin_hi, pin_lo, exp_hi, exp_lo, $time);
         end
      end
   end

   task automatic step(int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   task automatic rnd_pwm();
      pwm_hi_in = 1'($urandom); pwm_lo_in = 1'($urandom);
   endtask

   initial begin
      #(200000 * 5);
      if (!done) begin
         done = 1; errors++;
         $display("FAIL watchdog expired");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      // R1: reset state, held several cycles
      phase = "R1";
      step(4);
      rst_n = 1'b1;
      step(2);
      // R10: configure normal mode, no swap, immediate, while disabled
      phase = "R10_cfg";
      fault_indep = 0; swap_en = 0; ovr_sync = 0;
      step(2);
      mod_en = 1;
      // R3: raw passthrough
      phase = "R3_raw";
      for (int i = 0; i < 20; i++) begin rnd_pwm(); step(1); end
      // R6 / R8: immediate override
      phase = "R8_imm_ovr";
      ovr_en = 1;
      for (int i = 0; i < 16; i++) begin rnd_pwm(); ovr_dat = 2'(i); step(1); end
      // R4: current limit over override, normal mode
      phase = "R4_ilim";
      for (int i = 0; i < 16; i++) begin
         rnd_pwm(); ilim_act = 1'($urandom); ilim_dat = 2'($urandom); ovr_dat = 2'($urandom);
         step(1);
      end
      // R2: disable drops pins
      phase = "R2_disable";
      mod_en = 0; step(3); mod_en = 1; step(2);
      // R10: config change while enabled must be ignored
      phase = "R10_ignored";
      fault_indep = 1; swap_en = 1; ovr_sync = 1;
      ilim_act = 1; ilim_dat = 2'b10; ovr_en = 1; ovr_dat = 2'b01;
      step(6);
      // R5 / R7: apply independent mode and swap via disable
      phase = "R5_R7";
      mod_en = 0; ovr_sync = 0; step(2); mod_en = 1;
      for (int i = 0; i < 20; i++) begin
         rnd_pwm(); ilim_act = 1'($urandom); ilim_dat = 2'($urandom);
         ovr_en = 1'($urandom); ovr_dat = 2'($urandom); step(1);
      end
      // R9: synchronized override
      phase = "R9_sync";
      mod_en = 0; ovr_sync = 1; fault_indep = 0; swap_en = 0; ilim_act = 0; step(2);
      mod_en = 1;
      for (int i = 0; i < 40; i++) begin
         rnd_pwm(); ovr_en = 1'($urandom); ovr_dat = 2'($urandom);
         period_strobe = (i % 7 == 6); step(1);
      end
      period_strobe = 0;
      // mixed random over all inputs
      phase = "random";
      for (int i = 0; i < 600; i++) begin
         rnd_pwm();
         mod_en = ($urandom % 16) != 0;
         ilim_act = 1'($urandom); ilim_dat = 2'($urandom);
         fault_indep = 1'($urandom); swap_en = 1'($urandom); ovr_sync = 1'($urandom);
         ovr_en = 1'($urandom); ovr_dat = 2'($urandom);
         period_strobe = ($urandom % 5) == 0;
         step(1);
      end
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule